// File: doc/BRIEF.md
# I2C Register-Bank Preset Loader

After reset, this block writes a fixed set of configuration bytes into a banked I2C slave. It works as an I2C master on the write side only. It waits for a start-up delay and then handles six register banks in ascending order. For each bank it runs two transactions:

- A short write that stores the bank number in the slave's bank-pointer register.
- A burst write that gives a start register, followed by every preset byte of that bank. The slave advances its register address by itself after each byte.

The preset bytes come from an on-chip ROM. The ROM contents are set by parameters. Each bank reads the ROM from a base offset equal to the sum of the lengths of the banks before it.

The bus lines are open-drain. For each line the block drives one output enable, and an asserted enable pulls the line low. Every byte, including the address byte, must be acknowledged.

- **Normal finish:** after the last bank, the block raises `done`, releases the bus and blinks a status LED at a fixed half period.
- **Missing acknowledge:** the block ends the transfer with a STOP, raises `error` and starts no further transaction. The LED, which is lit from reset, then stays lit.

Top module: `preset_loader`

## Requirements
- R1: In reset and afterwards until `done` is set, `led` is 1, `sda_oe`, `scl_oe`, `done` and `error` are 0 while in reset.
- R2: The first START (SDA falling while SCL is released) occurs no earlier than DELAY_CYCLES clocks after reset is released, and no later than 4*QUARTER_CYCLES+8 clocks after that.
- R3: The first byte of every transaction is the address byte 0x2E, sent unchanged (its lowest bit, the write flag, is already 0).
- R4: A bank-select transaction is START, 0x2E, pointer 0xF0, the bank number, then STOP.
- R5: Banks are visited in the order 0,1,2,3,4,5, and each bank's select transaction comes directly before that bank's data transaction.
- R6: A data transaction is START, 0x2E, start register (0x40 for bank 0, 0x00 for banks 1 to 5), the bank's data bytes, then STOP.
- R7: Bank b sends BANK_LEN[b] bytes (32,144,64,128,96,112 by default). Byte k is ROM[base_b+k], where base_b is the sum of the lengths of banks 0 to b-1 and ROM entry i holds (i*ROM_MUL+ROM_ADD) mod 256.
- R8: Bytes go out MSB first. SDA changes only while SCL is low, except for START and STOP (SDA rising while SCL is released). Each SCL high pulse inside a transaction lasts exactly 2*QUARTER_CYCLES clocks.
- R9: The acknowledge is sampled during the ninth SCL pulse of each byte. If SDA is high there, the block sends STOP, sets `error` permanently, starts no further transaction and never sets `done`.
- R10: Once `error` is set, `led` stays 1.
- R11: `done` rises only after the final STOP of bank 5 and then stays 1 with both lines released.
- R12: While `done` is set, `led` toggles exactly every BLINK_CYCLES clocks.
- R13: An output enable of 1 pulls its line low. When the block is idle, finished or failed, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| done | output | 1 | All banks written successfully |
| error | output | 1 | Sequence aborted on a missing acknowledge |
| led | output | 1 | Status LED (1 = lit) |

## Verification
A wrong sequencer state shows up on the bus within one byte time. A skipped or repeated state gives a wrong byte, a STOP in the wrong place or a bank out of order, and each of these is detected at the next byte boundary. A ROM base or index that is off by one corrupts the first data byte of the affected bank. A bit engine whose phases are off either moves SDA while SCL is high or gives an SCL high pulse of the wrong length, and both are detected at the next SCL falling edge. Faults in the acknowledge handling or the LED show up as a wrong `error` or `done` level, or a wrong blink interval, within one blink period.

// File: rtl/preset_loader_pkg.sv
`timescale 1ns/1ps
package preset_loader_pkg;

  typedef enum logic [1:0] {
    CMD_START,
    CMD_BYTE,
    CMD_STOP
  } i2c_cmd_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_START,
    ENG_BITS,
    ENG_STOP
  } eng_state_e;

  typedef enum logic [3:0] {
    SQ_WAIT,
    SQ_SEL_START,
    SQ_SEL_ADDR,
    SQ_SEL_PTR,
    SQ_SEL_BANK,
    SQ_SEL_STOP,
    SQ_DAT_START,
    SQ_DAT_ADDR,
    SQ_DAT_REG,
    SQ_DAT_BYTE,
    SQ_DAT_STOP,
    SQ_ABORT_STOP,
    SQ_DONE,
    SQ_FAIL
  } seq_state_e;

  localparam logic [7:0] DEV_WRITE_ADDR = 8'h2E;
  localparam logic [7:0] BANK_PTR_REG   = 8'hF0;

endpackage

// File: rtl/i2c_write_engine.sv
`timescale 1ns/1ps
module i2c_write_engine
  import preset_loader_pkg::*;
#(
  parameter int unsigned QUARTER_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  i2c_cmd_e   cmd_kind,
  input  logic [7:0] cmd_byte,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       cmd_done,
  output logic       nack,
  output logic       framing
);

  localparam int unsigned QW = $clog2(QUARTER_CYCLES + 1);

  eng_state_e  st;
  logic [QW-1:0] qcnt;
  logic [1:0]  phase;
  logic [3:0]  bitn;
  logic [7:0]  shreg;

  assign framing = (st == ENG_START) || (st == ENG_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      qcnt     <= '0;
      phase    <= '0;
      bitn     <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      cmd_done <= 1'b0;
      nack     <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (st == ENG_IDLE) begin
        if (cmd_valid) begin
          qcnt  <= '0;
          phase <= '0;
          case (cmd_kind)
            CMD_START: st <= ENG_START;
            CMD_BYTE: begin
              st     <= ENG_BITS;
              shreg  <= cmd_byte;
              bitn   <= '0;
              nack   <= 1'b0;
              sda_oe <= ~cmd_byte[7];
            end
            default: begin
              st     <= ENG_STOP;
              sda_oe <= 1'b1;
            end
          endcase
        end
      end else if (qcnt != QW'(QUARTER_CYCLES - 1)) begin
        qcnt <= qcnt + 1'b1;
      end else begin
        qcnt  <= '0;
        phase <= phase + 1'b1;
        case (st)
          ENG_START: begin
            if (phase == 2'd0)      sda_oe <= 1'b1;
            else if (phase == 2'd1) scl_oe <= 1'b1;
            else begin
              st       <= ENG_IDLE;
              cmd_done <= 1'b1;
            end
          end
          ENG_STOP: begin
            if (phase == 2'd0)      scl_oe <= 1'b0;
            else if (phase == 2'd1) sda_oe <= 1'b0;
            else begin
              st       <= ENG_IDLE;
              cmd_done <= 1'b1;
            end
          end
          default: begin
            case (phase)
              2'd0: scl_oe <= 1'b0;
              2'd1: if (bitn == 4'd8) nack <= sda_i;
              2'd2: scl_oe <= 1'b1;
              default: begin
                if (bitn == 4'd8) begin
                  st       <= ENG_IDLE;
                  cmd_done <= 1'b1;
                end else begin
                  bitn   <= bitn + 1'b1;
                  shreg  <= {shreg[6:0], 1'b0};
                  sda_oe <= (bitn == 4'd7) ? 1'b0 : ~shreg[6];
                end
              end
            endcase
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/preset_rom.sv
`timescale 1ns/1ps
module preset_rom #(
  parameter int unsigned DEPTH = 576,
  parameter int unsigned AW    = 10,
  parameter int unsigned MUL   = 7,
  parameter int unsigned ADD   = 3
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) begin
      mem[i] = 8'((i * MUL + ADD) % 256);
    end
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end

endmodule

// File: rtl/led_blinker.sv
`timescale 1ns/1ps
module led_blinker #(
  parameter int unsigned BLINK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic finished,
  input  logic failed,
  output logic led
);

  localparam int unsigned CW = $clog2(BLINK_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      led <= 1'b1;
    end else if (failed) begin
      cnt <= '0;
      led <= 1'b1;
    end else if (finished) begin
      if (cnt == CW'(BLINK_CYCLES - 1)) begin
        cnt <= '0;
        led <= ~led;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/preset_loader.sv
`timescale 1ns/1ps
module preset_loader
  import preset_loader_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES    = 50_000_000,
  parameter int unsigned BLINK_CYCLES    = 50_000_000,
  parameter int unsigned QUARTER_CYCLES  = 250,
  parameter int unsigned NUM_BANKS       = 6,
  parameter int unsigned BANK_LEN [NUM_BANKS] = '{32, 144, 64, 128, 96, 112},
  parameter logic [7:0]  FIRST_START_REG = 8'h40,
  parameter logic [7:0]  OTHER_START_REG = 8'h00,
  parameter int unsigned ROM_MUL         = 7,
  parameter int unsigned ROM_ADD         = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_i,
  output logic sda_oe,
  output logic scl_oe,
  output logic done,
  output logic error,
  output logic led
);

  function automatic int unsigned len_sum(input int unsigned upto);
    int unsigned s = 0;
    for (int unsigned i = 0; i < upto; i++) s += BANK_LEN[i];
    return s;
  endfunction

  localparam int unsigned ROM_DEPTH = len_sum(NUM_BANKS);
  localparam int unsigned AW  = $clog2(ROM_DEPTH);
  localparam int unsigned LW  = $clog2(ROM_DEPTH + 1);
  localparam int unsigned BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned DW  = $clog2(DELAY_CYCLES + 1);

  logic [AW-1:0] bank_base [NUM_BANKS];
  logic [LW-1:0] bank_len  [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_base[g] = AW'(len_sum(g));
    assign bank_len[g]  = LW'(BANK_LEN[g]);
  end

  seq_state_e    st, next_st;
  logic [BW-1:0] bank;
  logic [LW-1:0] idx;
  logic [DW-1:0] wait_cnt;
  logic          pend;
  logic          cmd_valid;
  i2c_cmd_e      cmd_kind, issue_kind;
  logic [7:0]    cmd_byte, issue_byte;
  logic [7:0]    rom_q;
  logic [AW-1:0] rom_addr;
  logic          eng_done, eng_nack, eng_framing;
  logic          last_bank;

  assign rom_addr  = bank_base[bank] + AW'(idx);
  assign last_bank = (bank == BW'(NUM_BANKS - 1));

  preset_rom #(
    .DEPTH(ROM_DEPTH), .AW(AW), .MUL(ROM_MUL), .ADD(ROM_ADD)
  ) u_rom (
    .clk(clk), .addr(rom_addr), .q(rom_q)
  );

  i2c_write_engine #(
    .QUARTER_CYCLES(QUARTER_CYCLES)
  ) u_eng (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_byte(cmd_byte), .sda_i(sda_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .cmd_done(eng_done), .nack(eng_nack), .framing(eng_framing)
  );

  led_blinker #(
    .BLINK_CYCLES(BLINK_CYCLES)
  ) u_led (
    .clk(clk), .rst(rst), .finished(done), .failed(error), .led(led)
  );

  always_comb begin
    issue_kind = CMD_BYTE;
    issue_byte = 8'h00;
    next_st    = st;
    case (st)
      SQ_SEL_START: begin issue_kind = CMD_START; next_st = SQ_SEL_ADDR; end
      SQ_SEL_ADDR:  begin issue_byte = DEV_WRITE_ADDR; next_st = SQ_SEL_PTR; end
      SQ_SEL_PTR:   begin issue_byte = BANK_PTR_REG; next_st = SQ_SEL_BANK; end
      SQ_SEL_BANK:  begin issue_byte = 8'(bank); next_st = SQ_SEL_STOP; end
      SQ_SEL_STOP:  begin issue_kind = CMD_STOP; next_st = SQ_DAT_START; end
      SQ_DAT_START: begin issue_kind = CMD_START; next_st = SQ_DAT_ADDR; end
      SQ_DAT_ADDR:  begin issue_byte = DEV_WRITE_ADDR; next_st = SQ_DAT_REG; end
      SQ_DAT_REG: begin
        issue_byte = (bank == '0) ? FIRST_START_REG : OTHER_START_REG;
        next_st    = SQ_DAT_BYTE;
      end
      SQ_DAT_BYTE: begin
        issue_byte = rom_q;
        next_st    = (idx == bank_len[bank]) ? SQ_DAT_STOP : SQ_DAT_BYTE;
      end
      SQ_DAT_STOP: begin
        issue_kind = CMD_STOP;
        next_st    = last_bank ? SQ_DONE : SQ_SEL_START;
      end
      SQ_ABORT_STOP: begin issue_kind = CMD_STOP; next_st = SQ_FAIL; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_WAIT;
      bank      <= '0;
      idx       <= '0;
      wait_cnt  <= '0;
      pend      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_START;
      cmd_byte  <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      case (st)
        SQ_WAIT: begin
          if (wait_cnt == DW'(DELAY_CYCLES - 1)) st <= SQ_SEL_START;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        SQ_DONE: done  <= 1'b1;
        SQ_FAIL: error <= 1'b1;
        default: begin
          if (!pend) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= issue_kind;
            cmd_byte  <= issue_byte;
            pend      <= 1'b1;
            if (st == SQ_DAT_BYTE) idx <= idx + 1'b1;
          end else if (eng_done) begin
            pend <= 1'b0;
            if (issue_kind == CMD_BYTE && eng_nack) begin
              st <= SQ_ABORT_STOP;
            end else begin
              st <= next_st;
              if (st == SQ_DAT_STOP && !last_bank) begin
                bank <= bank + 1'b1;
                idx  <= '0;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/preset_loader_chk.sv
`timescale 1ns/1ps
module preset_loader_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic scl_oe,
  input logic framing,
  input logic done,
  input logic error,
  input logic led
);

  AST_LED_LIT_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    !done |-> led); // R1

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> framing); // R8

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
    error |=> error); // R9

  AST_NO_DONE_WITH_ERROR: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9

  AST_LED_SOLID_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    error |-> led); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R11

  AST_DONE_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sda_oe && !scl_oe)); // R13

endmodule

bind preset_loader preset_loader_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .framing(eng_framing), .done(done), .error(error), .led(led)
);

// File: tb/preset_loader_tb_top.sv
`timescale 1ns/1ps
module preset_loader_tb_top;

  localparam int DELAY   = 1000;
  localparam int BLINK   = 500;
  localparam int Q       = 2;
  localparam int NB      = 6;
  localparam int MUL     = 7;
  localparam int ADD     = 3;
  localparam int NACK_AT = 30;
  localparam int LENS [NB] = '{32, 144, 64, 128, 96, 112};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_oe, scl_oe, done, error, led;
  logic pull = 1'b0;
  logic sda_i;

  assign sda_i = !(sda_oe || pull);

  always #5 clk = ~clk;

  preset_loader #(
    .DELAY_CYCLES(DELAY), .BLINK_CYCLES(BLINK), .QUARTER_CYCLES(Q),
    .ROM_MUL(MUL), .ROM_ADD(ADD)
  ) dut_i (
    .clk(clk), .rst(rst), .sda_i(sda_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .done(done), .error(error), .led(led)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  int    exp_q [$];
  string tag_q [$];

  task automatic build_expected();
    int base = 0;
    exp_q.delete();
    tag_q.delete();
    for (int b = 0; b < NB; b++) begin
      exp_q.push_back(8'h2E); tag_q.push_back("R3");
      exp_q.push_back(8'hF0); tag_q.push_back("R4");
      exp_q.push_back(b);     tag_q.push_back("R5");
      exp_q.push_back(256);   tag_q.push_back("R4");
      exp_q.push_back(8'h2E); tag_q.push_back("R3");
      exp_q.push_back(b == 0 ? 8'h40 : 8'h00); tag_q.push_back("R6");
      for (int k = 0; k < LENS[b]; k++) begin
        exp_q.push_back(((base + k) * MUL + ADD) % 256); tag_q.push_back("R7");
      end
      exp_q.push_back(256); tag_q.push_back("R6");
      base += LENS[b];
    end
  endtask

  task automatic expect_item(input int v);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R5", v, -1);
    end else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(v == e, t, v, e);
    end
  endtask

  // Behavioural slave and bus model, evaluated every clock away from the edge
  bit nack_mode = 0;
  bit pscl, psda, ack_phase, hi_valid, first_start, aborted, post_abort;
  int bitcnt, hi_len, cyc, byte_no, last_toggle, toggles, starts;
  bit pled;
  logic [7:0] rx;

  always @(negedge clk) begin
    bit scl, sda;
    if (rst) begin
      pscl = 1; psda = 1; ack_phase = 0; hi_valid = 0; first_start = 0;
      aborted = 0; post_abort = 0; bitcnt = 0; hi_len = 0; cyc = 0;
      byte_no = 0; last_toggle = -1; toggles = 0; starts = 0; pull = 0;
      pled = 1; rx = '0;
    end else begin
      cyc++;
      scl = !scl_oe;
      sda = !(sda_oe || pull);
      if (scl && pscl && psda && !sda) begin
        starts++;
        if (!first_start) begin
          first_start = 1;
          chk(cyc >= DELAY && cyc <= DELAY + 4*Q + 8, "R2", cyc, DELAY);
        end
        chk(bitcnt == 0 && !ack_phase, "R8", bitcnt, 0);
        if (post_abort) chk(1'b0, "R9", starts, 0);
        hi_valid = 0;
        bitcnt = 0;
      end else if (scl && pscl && !psda && sda) begin
        chk(bitcnt == 1 && !ack_phase, "R8", bitcnt, 1);
        bitcnt = 0;
        if (aborted) begin
          chk(1'b1, "R9", 1, 1);
          aborted = 0;
          post_abort = 1;
        end else begin
          expect_item(256);
        end
      end
      if (scl && !pscl) begin
        hi_len = 1;
        hi_valid = 1;
        if (!ack_phase) begin
          rx = {rx[6:0], sda};
          bitcnt++;
        end
      end else if (scl) begin
        hi_len++;
      end
      if (!scl && pscl) begin
        if (hi_valid) chk(hi_len == 2*Q, "R8", hi_len, 2*Q);
        if (ack_phase) begin
          ack_phase = 0;
          pull = 0;
          bitcnt = 0;
        end else if (bitcnt == 8) begin
          if (aborted || post_abort) chk(1'b0, "R9", rx, -1);
          else expect_item(rx);
          ack_phase = 1;
          if (nack_mode && byte_no == NACK_AT) begin
            pull = 0;
            aborted = 1;
          end else begin
            pull = 1;
          end
          byte_no++;
        end
      end
      if (!done && !led) chk(1'b0, "R1", led, 1);
      if (done && exp_q.size() != 0) chk(1'b0, "R11", exp_q.size(), 0);
      if (done && error) chk(1'b0, "R9", error, 0);
      if (done && led != pled) begin
        if (last_toggle >= 0) chk(cyc - last_toggle == BLINK, "R12", cyc - last_toggle, BLINK);
        last_toggle = cyc;
        toggles++;
      end
      pled = led;
      pscl = scl;
      psda = sda;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(120000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Run 1: full load, then blinking
    build_expected();
    rst = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(led == 1'b1, "R1", led, 1);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R13", {sda_oe, scl_oe}, 0);
    chk(done == 1'b0 && error == 1'b0, "R1", {done, error}, 0);
    rst = 0;
    wait (done === 1'b1);
    @(negedge clk);
    chk(exp_q.size() == 0, "R11", exp_q.size(), 0);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R13", {sda_oe, scl_oe}, 0);
    chk(error == 1'b0, "R9", error, 0);
    wait (toggles >= 4);
    @(negedge clk);
    chk(toggles >= 4, "R12", toggles, 4);
    chk(done == 1'b1, "R11", done, 1);

    // Run 2: reset mid-blink, slave refuses byte NACK_AT
    rst = 1;
    nack_mode = 1;
    build_expected();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(led == 1'b1 && done == 1'b0 && error == 1'b0, "R1", {led, done, error}, 4);
    rst = 0;
    wait (error === 1'b1);
    @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
    chk(led == 1'b1, "R10", led, 1);
    chk(post_abort == 1'b1, "R9", post_abort, 1);
    repeat (3 * BLINK) @(posedge clk);
    @(negedge clk);
    chk(led == 1'b1, "R10", led, 1);
    chk(error == 1'b1 && done == 1'b0, "R9", {error, done}, 2);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R13", {sda_oe, scl_oe}, 0);
    chk(byte_no == NACK_AT + 1, "R9", byte_no, NACK_AT + 1);
    summary();
  end

endmodule